// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This unit executes the second opcode page of an 8-bit processor, the page reached through a prefix byte. Each of the 256 codes on that page works on one 8-bit operand. The caller fetches that operand from a register or from memory and presents it together with the opcode and the current flags.

One clock later the unit returns four things:
- the new value;
- a write-enable that says whether that value must be stored back;
- the index of the operand it belongs to;
- the updated flags.

The opcode is split into three fields:
- bits 7:6 pick the family: shift/rotate, bit test, bit clear or bit set;
- bits 5:3 pick either the shift kind or the bit number;
- bits 2:0 name the operand slot.

The unit never touches the register file or memory itself. It is a purely arithmetic stage between an operand read and a write-back.

Top module: `prefix_bit_unit`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly the following cycle, with that request's results. When no request was accepted at the previous edge, `out_valid` and `wr_en` are low. After reset `out_valid` is low.
- R2: `reg_sel` equals opcode bits 2:0 of the request. The slots are encoded 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A.
- R3: Opcode bits 7:6 = 00 selects a shift or rotate whose kind comes from bits 5:3. Kind 0 rotates left circularly: bit 7 goes to bit 0 and to carry. Kind 1 rotates right circularly: bit 0 goes to bit 7 and to carry.
- R4: Kind 2 rotates left through carry: the old carry enters bit 0 and bit 7 leaves into carry. Kind 3 rotates right through carry: the old carry enters bit 7 and bit 0 leaves into carry.
- R5: Kind 4 shifts left, filling bit 0 with 0. Kind 5 shifts right and keeps bit 7. Kind 7 shifts right, filling bit 7 with 0.
- R6: Flags use the encoding bit 3 zero, bit 2 subtract, bit 1 half-carry, bit 0 carry. Every shift and rotate clears subtract and half-carry, takes carry from the bit shifted out, and sets zero exactly when the result is 0.
- R7: Kind 6 exchanges the two nibbles. It clears subtract, half-carry and carry, and sets zero when the result is 0.
- R8: Bits 7:6 = 01 tests bit n, where n is opcode bits 5:3. It sets zero when that bit is 0, sets half-carry, clears subtract and keeps the incoming carry. The result equals the operand.
- R9: Bits 7:6 = 10 clears bit n and bits 7:6 = 11 sets bit n. All other bits of the operand are kept, and the flags leave unchanged.
- R10: `wr_en` is high with every valid result except a bit test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Second-page opcode |
| operand | input | 8 | Operand value |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result present this cycle |
| result | output | 8 | New operand value |
| wr_en | output | 1 | Store result back to the slot |
| reg_sel | output | 3 | Operand slot of the result |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |

## Verification
Every result, flag value, slot index and write-enable is due one edge after the request is accepted. Nothing is valid in any other cycle.

The driver enters each request at a falling edge and pushes the expected item into a queue at that moment. The monitor looks at the outputs shortly after each rising edge. When it sees `out_valid`, it pops the oldest item and compares it with the outputs.

A valid output with an empty queue counts as a failure. So does an item still in the queue at the end. Both catch a result that arrives at the wrong cycle as well as one with the wrong value.

// File: rtl/prefix_bit_unit.sv
module prefix_bit_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] opcode,
  input  logic [7:0] operand,
  input  logic [3:0] flags_in,
  output logic       out_valid,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [2:0] reg_sel,
  output logic [3:0] flags_out
);
  localparam int DW   = 8;
  localparam int HALF = DW / 2;

  logic [1:0]    family;
  logic [2:0]    field;
  logic          cin;
  logic [DW-1:0] mask;
  logic [DW-1:0] nxt;
  logic          cout;
  logic [3:0]    nflags;
  logic          nwe;
  logic          we_q;

  assign family = opcode[7:6];
  assign field  = opcode[5:3];
  assign cin    = flags_in[0];
  assign mask   = DW'(1) << field;

  always_comb begin
    nxt    = operand;
    cout   = 1'b0;
    nwe    = 1'b1;
    nflags = flags_in;
    unique case (family)
      2'b00: begin
        unique case (field)
          3'd0: begin nxt = {operand[DW-2:0], operand[DW-1]}; cout = operand[DW-1]; end
          3'd1: begin nxt = {operand[0], operand[DW-1:1]};    cout = operand[0];    end
          3'd2: begin nxt = {operand[DW-2:0], cin};           cout = operand[DW-1]; end
          3'd3: begin nxt = {cin, operand[DW-1:1]};           cout = operand[0];    end
          3'd4: begin nxt = {operand[DW-2:0], 1'b0};          cout = operand[DW-1]; end
          3'd5: begin nxt = {operand[DW-1], operand[DW-1:1]}; cout = operand[0];    end
          3'd6: begin nxt = {operand[HALF-1:0], operand[DW-1:HALF]}; cout = 1'b0;   end
          default: begin nxt = {1'b0, operand[DW-1:1]};       cout = operand[0];    end
        endcase
        nflags = {nxt == '0, 1'b0, 1'b0, cout};
      end
      2'b01: begin
        nwe    = 1'b0;
        nflags = {~operand[field], 1'b0, 1'b1, cin};
      end
      2'b10:   nxt = operand & ~mask;
      default: nxt = operand | mask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      we_q      <= 1'b0;
      reg_sel   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt;
        we_q      <= nwe;
        reg_sel   <= opcode[2:0];
        flags_out <= nflags;
      end
    end
  end

  assign wr_en = out_valid & we_q;
endmodule

module prefix_bit_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] opcode,
  input logic [7:0] operand,
  input logic [3:0] flags_in,
  input logic       out_valid,
  input logic [7:0] result,
  input logic       wr_en,
  input logic [2:0] reg_sel,
  input logic [3:0] flags_out
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en);
  assert_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> reg_sel == $past(opcode[2:0]));
  assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[7:3] == 5'b00110 |=>
      result == {$past(operand[3:0]), $past(operand[7:4])} && flags_out[2:0] == 3'b000);
  assert_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[7:6] == 2'b01 |=>
      !wr_en && flags_out[2:1] == 2'b01 && flags_out[0] == $past(flags_in[0])
      && result == $past(operand));
  assert_setclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[7] |=> flags_out == $past(flags_in) && wr_en);
  assert_shift_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[7:6] == 2'b00 |=>
      flags_out[2:1] == 2'b00 && flags_out[3] == (result == 8'h00));
endmodule

bind prefix_bit_unit prefix_bit_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
  .result(result), .wr_en(wr_en), .reg_sel(reg_sel), .flags_out(flags_out)
);

// File: tb/prefix_bit_unit_tb.sv
module prefix_bit_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [7:0] operand = '0;
  logic [3:0] flags_in = '0;
  logic       out_valid;
  logic [7:0] result;
  logic       wr_en;
  logic [2:0] reg_sel;
  logic [3:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] res;
    logic [3:0] fl;
    logic       we;
    logic [2:0] sel;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  prefix_bit_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .reg_sel(reg_sel), .flags_out(flags_out)
  );

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:6] == 2'b01) return "R8";
    if (op[7]) return "R9";
    case (op[5:3])
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd6:       return "R7";
      default:    return "R5";
    endcase
  endfunction

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] v, input logic [3:0] f);
    exp_t e;
    logic c;
    int n;
    n = int'(op[5:3]);
    e.sel = op[2:0];
    e.we  = 1'b1;
    e.tag = tag_of(op);
    e.fl  = f;
    e.res = v;
    c = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (n)
          0: begin e.res = (v << 1) | (v >> 7); c = v[7]; end
          1: begin e.res = (v >> 1) | (v << 7); c = v[0]; end
          2: begin e.res = (v << 1) | {7'd0, f[0]}; c = v[7]; end
          3: begin e.res = (v >> 1) | {f[0], 7'd0}; c = v[0]; end
          4: begin e.res = v << 1; c = v[7]; end
          5: begin e.res = (v >> 1) | (v & 8'h80); c = v[0]; end
          6: begin e.res = (v << 4) | (v >> 4); c = 1'b0; end
          default: begin e.res = v >> 1; c = v[0]; end
        endcase
        e.fl = {e.res == 8'h00, 1'b0, 1'b0, c};
      end
      2'b01: begin
        e.we = 1'b0;
        e.fl = {((v >> n) & 8'h01) == 8'h00, 1'b0, 1'b1, f[0]};
      end
      2'b10: e.res = v & ~(8'h01 << n);
      default: e.res = v | (8'h01 << n);
    endcase
    return e;
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] v, input logic [3:0] f);
    @(negedge clk);
    opcode = op; operand = v; flags_in = f; in_valid = 1'b1;
    sb.push_back(model(op, v, f));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1", "unexpected out_valid", 8'h01, 8'h00);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res, e.tag, "result", result, e.res);
        chk(flags_out == e.fl, (e.tag == "R8" || e.tag == "R9" || e.tag == "R7") ? e.tag : "R6",
            "flags", {4'h0, flags_out}, {4'h0, e.fl});
        chk(wr_en == e.we, "R10", "wr_en", {7'd0, wr_en}, {7'd0, e.we});
        chk(reg_sel == e.sel, "R2", "reg_sel", {5'd0, reg_sel}, {5'd0, e.sel});
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && wr_en == 1'b0, "R1", "reset state", {7'd0, out_valid}, 8'h00);
    rst_n = 1'b1;
    idle(2);
    // R3 circular rotates
    send(8'h00, 8'h85, 4'h0);
    send(8'h09, 8'h01, 4'h0);
    // R4 rotate through carry
    send(8'h12, 8'h80, 4'h0);
    send(8'h1B, 8'h01, 4'h1);
    send(8'h13, 8'h40, 4'h1);
    // R5 shifts
    send(8'h24, 8'hFF, 4'h0);
    send(8'h2D, 8'h81, 4'h0);
    send(8'h3F, 8'h01, 4'h0);
    send(8'h3E, 8'h80, 4'h1);
    // R7 swap
    send(8'h37, 8'hF0, 4'hF);
    send(8'h30, 8'h00, 4'h1);
    idle(3);
    // R1 gap: nothing valid while idle
    chk(out_valid == 1'b0, "R1", "idle out_valid", {7'd0, out_valid}, 8'h00);
    // R8 bit test
    send(8'h7F, 8'h7F, 4'h1);
    send(8'h41, 8'h01, 4'h0);
    // R9 clear and set, flags pass through
    send(8'h9E, 8'hFF, 4'hA);
    send(8'hF8, 8'h00, 4'h5);
    // sweep of the whole page with several patterns
    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 256; o++) begin
        send(8'(o), 8'(o * 37 + p * 91), 4'(o + p));
      end
      idle(1);
    end
    idle(4);
    chk(sb.size() == 0, "R1", "leftover expected items", 8'(sb.size()), 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule